// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers a set of peripheral interrupt sources into two shared requests toward the CPU. The first is a standard interrupt request. The second is a request for the microcoded transfer server. Each source has three bits. A pending bit latches the source's event. An enable bit gates it. A route bit chooses which of the two shared requests the source feeds. All three registers are reached through a small write/read register port.

When the CPU acknowledges one of the shared requests, the block picks the highest-numbered source that is pending, enabled and routed to that request. It clears that source's pending bit and, one cycle later, presents a vector offset. If no source qualifies, for example because software cleared the pending bit after the shared request was raised, a fixed dummy offset is presented instead.

The transfer server signals that a source's transfer count has reached zero. When it does, the block clears that source's route bit, and the source falls back to standard interrupts until software sets the bit again.

Top module: `pirq_aggregator`

## Requirements
- R1: After a synchronous reset, the pending, enable and route registers read 0. `std_req`, `pts_req` and `vec_valid` are low, and `vec_addr` is 0.
- R2: A high `src_evt[i]` on a clock edge sets pending bit i whatever the state of enable bit i. The pending register reads at `reg_addr` 0.
- R3: A write to `reg_addr` 0 loads the pending register with `reg_wdata`, so software can raise or drop any pending bit.
- R4: `std_req` is high exactly when some source is pending, enabled (`reg_addr` 1) and has its route bit clear (`reg_addr` 2). `pts_req` is high exactly when some source is pending, enabled and has its route bit set.
- R5: An `ack_std` or `ack_pts` pulse on an edge selects the highest-index qualifying source of that request. On the next cycle, `vec_valid` is high for one cycle and `vec_addr` holds 0x2100+4*i for a standard acknowledge, or 0x2102+4*i for a transfer acknowledge (source 15 gives 0x213E and source 0 gives 0x2102).
- R6: On the same edge as the acknowledge, the pending bit of the selected source is cleared.
- R7: An acknowledge with no qualifying source yields `vec_addr` 0x2014 for a standard acknowledge and 0x2016 for a transfer acknowledge, and clears no pending bit.
- R8: A high `cnt_zero[i]` clears route bit i. This takes precedence over a register write that sets the same bit on the same edge.
- R9: A hardware event on the same edge as a software write or an acknowledge that would clear its pending bit leaves that bit set.
- R10: When `ack_std` and `ack_pts` are high together, only the transfer acknowledge is served, and the standard request's sources keep their pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | 16 | Per-source event pulses |
| cnt_zero | input | 16 | Per-source transfer-count-exhausted pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 enable, 2 route, 3 unused |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| ack_std | input | 1 | Standard request acknowledge pulse |
| ack_pts | input | 1 | Transfer request acknowledge pulse |
| std_req | output | 1 | Shared standard interrupt request |
| pts_req | output | 1 | Shared transfer service request |
| vec_valid | output | 1 | Vector offset valid, one cycle after acknowledge |
| vec_addr | output | 16 | Vector offset |

## Verification
The acknowledge path is tested with several pending patterns:
- A single top-index source on the transfer route checks the upper end of the offset formula.
- Three adjacent standard sources drained one by one check both the priority order and that each acknowledge clears only its own bit.
- Lone source 0 on the transfer route checks the lower end of the formula.

Acknowledges with nothing qualifying check that the dummy offset depends on which request was acknowledged.

Same-edge collisions are applied one at a time, and each shows which side wins:
- an event against a clearing write;
- an event against an acknowledge;
- count exhaustion against a setting write;
- both acknowledges together.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [1:0] {
        RA_PEND = 2'd0,
        RA_EN   = 2'd1,
        RA_SEL  = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    localparam int unsigned VEC_W = 16;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] addr;
    } vec_out_t;

    function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                                 input int unsigned idx,
                                                 input int unsigned stride);
        return base + VEC_W'(idx * stride);
    endfunction

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] cnt_zero,
    input  logic [NUM_SRC-1:0] ack_clr,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic [NUM_SRC-1:0] pend_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] sel_q
);
    import pirq_pkg::*;

    reg_addr_e    ra;
    logic [NUM_SRC-1:0] pend_d, en_d, sel_d;

    assign ra = reg_addr_e'(reg_addr);

    always_comb begin
        pend_d = (reg_wr && ra == RA_PEND) ? reg_wdata : pend_q;
        pend_d = (pend_d & ~ack_clr) | src_evt;
        en_d   = (reg_wr && ra == RA_EN) ? reg_wdata : en_q;
        sel_d  = ((reg_wr && ra == RA_SEL) ? reg_wdata : sel_q) & ~cnt_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            en_q   <= '0;
            sel_q  <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            sel_q  <= sel_d;
        end
    end

    always_comb begin
        unique case (ra)
            RA_PEND: reg_rdata = pend_q;
            RA_EN:   reg_rdata = en_q;
            RA_SEL:  reg_rdata = sel_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pirq_prio.sv
module pirq_prio #(
    parameter int unsigned NUM_SRC = 16,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] onehot
);
    always_comb begin
        any    = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i]) begin
                any    = 1'b1;
                idx    = IDX_W'(i);
                onehot = '0;
                onehot[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pirq_vector.sv
module pirq_vector #(
    parameter int unsigned NUM_SRC   = 16,
    parameter logic [15:0] STD_BASE  = 16'h2100,
    parameter logic [15:0] PTS_BASE  = 16'h2102,
    parameter int unsigned STRIDE    = 4,
    parameter logic [15:0] STD_DUMMY = 16'h2014,
    parameter logic [15:0] PTS_DUMMY = 16'h2016,
    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_std,
    input  logic               ack_pts,
    input  logic               std_any,
    input  logic [IDX_W-1:0]   std_idx,
    input  logic [NUM_SRC-1:0] std_oh,
    input  logic               pts_any,
    input  logic [IDX_W-1:0]   pts_idx,
    input  logic [NUM_SRC-1:0] pts_oh,
    output logic [NUM_SRC-1:0] ack_clr,
    output pirq_pkg::vec_out_t vec_q
);
    import pirq_pkg::*;

    vec_out_t vec_d;

    always_comb begin
        vec_d   = '0;
        ack_clr = '0;
        if (ack_pts) begin
            vec_d.valid = 1'b1;
            if (pts_any) begin
                vec_d.addr = vec_of(PTS_BASE, int'(pts_idx), STRIDE);
                ack_clr    = pts_oh;
            end else begin
                vec_d.addr = PTS_DUMMY;
            end
        end else if (ack_std) begin
            vec_d.valid = 1'b1;
            if (std_any) begin
                vec_d.addr = vec_of(STD_BASE, int'(std_idx), STRIDE);
                ack_clr    = std_oh;
            end else begin
                vec_d.addr = STD_DUMMY;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
        end else begin
            vec_q.valid <= vec_d.valid;
            if (vec_d.valid) vec_q.addr <= vec_d.addr;
        end
    end
endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator #(
    parameter int unsigned NUM_SRC   = 16,
    parameter logic [15:0] STD_BASE  = 16'h2100,
    parameter logic [15:0] PTS_BASE  = 16'h2102,
    parameter int unsigned STRIDE    = 4,
    parameter logic [15:0] STD_DUMMY = 16'h2014,
    parameter logic [15:0] PTS_DUMMY = 16'h2016
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt,
    input  logic [NUM_SRC-1:0] cnt_zero,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               ack_std,
    input  logic               ack_pts,
    output logic               std_req,
    output logic               pts_req,
    output logic               vec_valid,
    output logic [15:0]        vec_addr
);
    import pirq_pkg::*;

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] pend_q, en_q, sel_q, ack_clr;
    logic [NUM_SRC-1:0] std_qual, pts_qual, std_oh, pts_oh;
    logic [IDX_W-1:0]   std_idx, pts_idx;
    logic               std_any, pts_any;
    vec_out_t           vec_q;

    pirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk(clk), .rst(rst), .src_evt(src_evt), .cnt_zero(cnt_zero),
        .ack_clr(ack_clr), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pend_q(pend_q), .en_q(en_q), .sel_q(sel_q)
    );

    assign std_qual = pend_q & en_q & ~sel_q;
    assign pts_qual = pend_q & en_q & sel_q;

    pirq_prio #(.NUM_SRC(NUM_SRC)) u_prio_std (
        .req(std_qual), .any(std_any), .idx(std_idx), .onehot(std_oh)
    );

    pirq_prio #(.NUM_SRC(NUM_SRC)) u_prio_pts (
        .req(pts_qual), .any(pts_any), .idx(pts_idx), .onehot(pts_oh)
    );

    pirq_vector #(
        .NUM_SRC(NUM_SRC), .STD_BASE(STD_BASE), .PTS_BASE(PTS_BASE),
        .STRIDE(STRIDE), .STD_DUMMY(STD_DUMMY), .PTS_DUMMY(PTS_DUMMY)
    ) u_vec (
        .clk(clk), .rst(rst), .ack_std(ack_std), .ack_pts(ack_pts),
        .std_any(std_any), .std_idx(std_idx), .std_oh(std_oh),
        .pts_any(pts_any), .pts_idx(pts_idx), .pts_oh(pts_oh),
        .ack_clr(ack_clr), .vec_q(vec_q)
    );

    assign std_req   = std_any;
    assign pts_req   = pts_any;
    assign vec_valid = vec_q.valid;
    assign vec_addr  = vec_q.addr;
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker #(
    parameter int unsigned NUM_SRC   = 16,
    parameter logic [15:0] STD_DUMMY = 16'h2014,
    parameter logic [15:0] PTS_DUMMY = 16'h2016
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_evt,
    input logic [NUM_SRC-1:0] cnt_zero,
    input logic               ack_std,
    input logic               ack_pts,
    input logic               std_req,
    input logic               pts_req,
    input logic               vec_valid,
    input logic [15:0]        vec_addr,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] sel_q
);
    // R2
    evt_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt)));

    // R5
    ack_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_std || ack_pts) |=> vec_valid);

    // R5
    no_ack_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(ack_std || ack_pts) |=> !vec_valid);

    // R7
    pts_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_pts && !pts_req) |=> (vec_addr == PTS_DUMMY));

    // R7
    std_dummy_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_std && !ack_pts && !std_req) |=> (vec_addr == STD_DUMMY));

    // R8
    cnt_zero_clears_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (|cnt_zero) |=> ((sel_q & $past(cnt_zero)) == '0));
endmodule

bind pirq_aggregator pirq_checker #(
    .NUM_SRC(NUM_SRC), .STD_DUMMY(STD_DUMMY), .PTS_DUMMY(PTS_DUMMY)
) i_pirq_checker (
    .clk(clk), .rst(rst), .src_evt(src_evt), .cnt_zero(cnt_zero),
    .ack_std(ack_std), .ack_pts(ack_pts), .std_req(std_req),
    .pts_req(pts_req), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .pend_q(pend_q), .sel_q(sel_q)
);

// File: tb/test_pirq_aggregator.sv
module test_pirq_aggregator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_evt = '0, cnt_zero = '0, reg_wdata = '0, reg_rdata;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        ack_std = 1'b0, ack_pts = 1'b0;
    logic        std_req, pts_req, vec_valid;
    logic [15:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    pirq_aggregator i_pirq_aggregator (
        .clk(clk), .rst(rst), .src_evt(src_evt), .cnt_zero(cnt_zero),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ack_std(ack_std), .ack_pts(ack_pts),
        .std_req(std_req), .pts_req(pts_req), .vec_valid(vec_valid),
        .vec_addr(vec_addr)
    );

    function automatic logic [15:0] std_vec(int i); return 16'h2100 + 16'(4*i); endfunction
    function automatic logic [15:0] pts_vec(int i); return 16'h2102 + 16'(4*i); endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // register write with optional same-edge side inputs
    task automatic wr(logic [1:0] a, logic [15:0] d,
                      logic [15:0] evt = '0, logic [15:0] cz = '0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; src_evt = evt; cnt_zero = cz;
        @(negedge clk);
        reg_wr = 1'b0; src_evt = '0; cnt_zero = '0;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // driver: push expected vector, then pulse the acknowledge
    task automatic ack(logic s, logic p, logic [15:0] exp, logic [15:0] evt = '0);
        @(negedge clk);
        exp_q.push_back(exp);
        ack_std = s; ack_pts = p; src_evt = evt;
        @(negedge clk);
        ack_std = 1'b0; ack_pts = 1'b0; src_evt = '0;
    endtask

    task automatic pulse_evt(logic [15:0] e, logic [15:0] cz = '0);
        @(negedge clk);
        src_evt = e; cnt_zero = cz;
        @(negedge clk);
        src_evt = '0; cnt_zero = '0;
    endtask

    // monitor: pops one expected vector per valid cycle (R5, R7)
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5: actual=%h expected=<none>", vec_addr);
            end else begin
                chk("R5/R7 vector", vec_addr, exp_q.pop_front());
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        rd("R1 pend", 2'd0, 16'h0000);
        rd("R1 en", 2'd1, 16'h0000);
        rd("R1 sel", 2'd2, 16'h0000);
        chk("R1 reqs/valid", {13'd0, std_req, pts_req, vec_valid}, 16'h0);
        chk("R1 vec_addr", vec_addr, 16'h0);

        // R2: masked event still latches
        pulse_evt(16'h0008);
        rd("R2 pend", 2'd0, 16'h0008);
        chk("R4 std_req masked", {15'd0, std_req}, 16'h0);

        // R4
        wr(2'd1, 16'hFFFF);
        #1 chk("R4 std_req", {15'd0, std_req}, 16'h1);
        chk("R4 pts_req", {15'd0, pts_req}, 16'h0);

        // R3
        wr(2'd0, 16'h8001);
        rd("R3 pend", 2'd0, 16'h8001);
        wr(2'd2, 16'h8000);
        #1 chk("R4 both reqs", {14'd0, std_req, pts_req}, 16'h3);

        // R5 upper end, R6
        ack(1'b0, 1'b1, pts_vec(15));
        rd("R6 pend after ack", 2'd0, 16'h0001);
        chk("R4 pts_req drop", {15'd0, pts_req}, 16'h0);

        // R7 pts dummy, nothing cleared
        ack(1'b0, 1'b1, 16'h2016);
        rd("R7 pend kept", 2'd0, 16'h0001);

        // R5 priority among standard sources
        wr(2'd0, 16'h0007);
        ack(1'b1, 1'b0, std_vec(2));
        ack(1'b1, 1'b0, std_vec(1));
        rd("R6 pend one left", 2'd0, 16'h0001);
        ack(1'b1, 1'b0, std_vec(0));
        ack(1'b1, 1'b0, 16'h2014);   // R7 standard dummy

        // R5 lower end
        wr(2'd2, 16'h0001);
        wr(2'd0, 16'h0001);
        ack(1'b0, 1'b1, pts_vec(0));

        // R8: count exhaustion beats setting write
        wr(2'd2, 16'hFFFF, 16'h0000, 16'h8000);
        rd("R8 sel", 2'd2, 16'h7FFF);
        pulse_evt(16'h0000, 16'h4000);
        rd("R8 sel second", 2'd2, 16'h3FFF);

        // R9: event vs clearing write
        wr(2'd0, 16'h0020);
        wr(2'd0, 16'h0000, 16'h0020);
        rd("R9 write collision", 2'd0, 16'h0020);
        // R9: event vs acknowledge clear (source 5 routed to transfer)
        ack(1'b0, 1'b1, pts_vec(5), 16'h0020);
        rd("R9 ack collision", 2'd0, 16'h0020);

        // R10: both acks together
        wr(2'd2, 16'h0020);
        wr(2'd0, 16'h0021);
        ack(1'b1, 1'b1, pts_vec(5));
        rd("R10 pend", 2'd0, 16'h0001);
        chk("R10 std_req kept", {15'd0, std_req}, 16'h1);

        repeat (3) @(negedge clk);
        chk("R5 scoreboard drained", 16'(exp_q.size()), 16'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule